// File: doc/BRIEF.md
# Tachometer Timer Register Front End

This block is the software-visible face of a two-channel tachometer timer. It sits on a simple request/response bus with byte addresses and a size qualifier. It holds the configuration the two counting channels need: prescale, clock gating, mode and enable bits, compare values, compare configuration and input selection. The channels themselves live outside the block. They report back through live counter and capture values, and through six single-cycle event pulses.

Each event pulse sets a sticky pending bit. Software clears pending bits through a separate write-one-to-clear register, which always reads back zero. An enable mask selects which pending bits can drive the single level interrupt output.

Every register insists on its own access width. The counter, capture and compare registers are 16 bits wide and take only 16-bit accesses. All other registers are 8 bits wide and take only byte accesses. A wrong-size access, or an access to an unmapped offset, completes with an error flag and changes nothing. Reset clears the configuration, enable and pending state. The counter and capture values are not stored here, so reset does not touch them.

Top module: `tachtmr_regif`

## Requirements
- R1: Register offsets are as follows. 16-bit registers: 0x00 counter 1, 0x02 capture A, 0x04 capture B, 0x06 counter 2, 0x14 compare A, 0x16 compare B. 8-bit registers: 0x08 prescale, 0x0A clock control, 0x0C mode control, 0x0E pending, 0x10 clear, 0x12 enable, 0x18 compare config, 0x1A input-A select, 0x1C input-B select.
- R2: `req_size` = 1 marks a 16-bit access and `req_size` = 0 marks a byte access. An access whose size does not match its register completes with `rsp_err` = 1 and `rsp_rdata` = 0, and a write of that kind modifies no register.
- R3: An odd address, offset 0x1E, or any address at 0x20 or above completes with `rsp_err` = 1 and `rsp_rdata` = 0.
- R4: Each request cycle produces exactly one response, with `rsp_valid` high in the following cycle. `rsp_valid` is low when no request was made in the previous cycle.
- R5: Reads of offsets 0x00, 0x02, 0x04 and 0x06 return the live channel inputs. Writes to those offsets, and writes to the pending register, have no effect.
- R6: The prescale, compare and select registers read back what was written. Byte reads are zero-extended. Each register's value appears on its output port.
- R7: A high bit on `evt_pulse` sets the matching pending bit, and that bit stays set until it is cleared. Bit layout: 0 capture A, 1 capture B, 2 underflow A, 3 underflow B, 4 compare-hit A, 5 compare-hit B.
- R8: A byte write to the clear register clears every pending bit where the written data holds a one. Reads of the clear register return zero.
- R9: If an event pulse and a clear write target the same pending bit in the same cycle, that bit ends up set.
- R10: `irq` goes high one cycle after any pending bit is set while its enable bit (same layout as R7) is set, and goes low one cycle after no such pair remains.
- R11: Reset clears prescale, clock control, mode, pending, enable, compare, compare config and both select registers, and holds `irq` low.
- R12: Decoded fields. Clock control: bit 0 gates channel 1 and bit 3 gates channel 2. Mode control: bit 6 enables B, bit 5 enables A, bit 4 is the B edge select, bit 3 is the A edge select, and bit 2 enables mode 5. Compare config: the low nibble belongs to A and the high nibble to B. Each select register uses bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 16 | Read data |
| rsp_err | output | 1 | Access rejected |
| cnt1_val | input | 16 | Live counter 1 from channel logic |
| cap_a_val | input | 16 | Live capture A |
| cap_b_val | input | 16 | Live capture B |
| cnt2_val | input | 16 | Live counter 2 |
| evt_pulse | input | NUM_EVT | Event pulses in pending-bit layout |
| prescale | output | 8 | Prescale divisor minus one |
| clk1_gate | output | 1 | Channel 1 clock enabled |
| clk2_gate | output | 1 | Channel 2 clock enabled |
| ch_a_en | output | 1 | Channel A enable |
| ch_b_en | output | 1 | Channel B enable |
| ch_a_edge | output | 1 | Channel A edge select |
| ch_b_edge | output | 1 | Channel B edge select |
| mode5_en | output | 1 | Mode 5 enable |
| cmp_a | output | 16 | Compare A value |
| cmp_b | output | 16 | Compare B value |
| cmp_cfg_a | output | 4 | Compare config, channel A |
| cmp_cfg_b | output | 4 | Compare config, channel B |
| in_sel_a | output | 1 | Input select, channel A |
| in_sel_b | output | 1 | Input select, channel B |
| irq | output | 1 | Level interrupt |

## Verification
The collision that matters is a clear write arriving at the pending bits in the same cycle as a channel event. The bench provokes it by raising `evt_pulse` on the same clock edge that carries a write-one-to-clear of overlapping bits. It then reads the pending register back through the bus. The bit that saw both the event and the clear must read as set, while a bit that was cleared with no event must read as zero. A second collision pairs a wrong-size write with the register it names. The bench judges that case from both the error flag and an unchanged read-back.

// File: rtl/tachtmr_pkg.sv
package tachtmr_pkg;
   localparam int HALF_W = 16;
   localparam int BYTE_W = 8;

   // Register index = byte offset / 2.
   typedef enum logic [3:0] {
      IX_CNT1 = 4'd0,  IX_CAPA = 4'd1,  IX_CAPB = 4'd2,  IX_CNT2 = 4'd3,
      IX_PRSC = 4'd4,  IX_CLKC = 4'd5,  IX_MODE = 4'd6,  IX_PEND = 4'd7,
      IX_CLR  = 4'd8,  IX_IEN  = 4'd9,  IX_CMPA = 4'd10, IX_CMPB = 4'd11,
      IX_CCFG = 4'd12, IX_SELA = 4'd13, IX_SELB = 4'd14, IX_NONE = 4'd15
   } reg_ix_e;

   // Field positions decoded by the channel logic.
   localparam int CLK1_BIT   = 0;
   localparam int CLK2_BIT   = 3;
   localparam int MODE5_BIT  = 2;
   localparam int EDGE_A_BIT = 3;
   localparam int EDGE_B_BIT = 4;
   localparam int EN_A_BIT   = 5;
   localparam int EN_B_BIT   = 6;

   typedef struct packed {
      logic [BYTE_W-1:0] prescale;
      logic [BYTE_W-1:0] clk_ctl;
      logic [BYTE_W-1:0] mode_ctl;
      logic [BYTE_W-1:0] int_en;
      logic [HALF_W-1:0] cmp_a;
      logic [HALF_W-1:0] cmp_b;
      logic [BYTE_W-1:0] cmp_cfg;
      logic [BYTE_W-1:0] sel_a;
      logic [BYTE_W-1:0] sel_b;
   } cfg_t;

   function automatic logic ix_is_half(reg_ix_e ix);
      return (ix == IX_CNT1) || (ix == IX_CAPA) || (ix == IX_CAPB) ||
             (ix == IX_CNT2) || (ix == IX_CMPA) || (ix == IX_CMPB);
   endfunction
endpackage

// File: rtl/tachtmr_decode.sv
module tachtmr_decode
   import tachtmr_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              size_half,
   output reg_ix_e           ix,
   output logic              err
);
   localparam int IX_LSB = 1;
   localparam int IX_MSB = 4;

   logic in_window;
   logic misaligned;

   assign in_window  = (addr[ADDR_W-1:IX_MSB+1] == '0);
   assign misaligned = addr[0];
   assign ix         = reg_ix_e'(addr[IX_MSB:IX_LSB]);

   always_comb begin
      err = 1'b0;
      if (!in_window || misaligned || ix == IX_NONE) err = 1'b1;
      else if (ix_is_half(ix) != size_half)          err = 1'b1;
   end
endmodule

// File: rtl/tachtmr_cfg_regs.sv
module tachtmr_cfg_regs
   import tachtmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  reg_ix_e           ix,
   input  logic [HALF_W-1:0] wdata,
   output cfg_t              cfg_q
);
   logic [BYTE_W-1:0] wb;
   assign wb = wdata[BYTE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_ok) begin
         unique case (ix)
            IX_PRSC: cfg_q.prescale <= wb;
            IX_CLKC: cfg_q.clk_ctl  <= wb;
            IX_MODE: cfg_q.mode_ctl <= wb;
            IX_IEN:  cfg_q.int_en   <= wb;
            IX_CMPA: cfg_q.cmp_a    <= wdata;
            IX_CMPB: cfg_q.cmp_b    <= wdata;
            IX_CCFG: cfg_q.cmp_cfg  <= wb;
            IX_SELA: cfg_q.sel_a    <= wb;
            IX_SELB: cfg_q.sel_b    <= wb;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/tachtmr_pending.sv
module tachtmr_pending #(
   parameter int NUM_EVT        = 6,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt,
   input  logic               clr_we,
   input  logic [NUM_EVT-1:0] clr_mask,
   input  logic [NUM_EVT-1:0] en,
   output logic [NUM_EVT-1:0] pend_q,
   output logic               irq
);
   logic [NUM_EVT-1:0] clr_eff;
   logic               irq_raw;

   assign clr_eff = clr_we ? clr_mask : '0;

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q[i] <= 1'b0;
         else        pend_q[i] <= evt[i] | (pend_q[i] & ~clr_eff[i]);
      end
   end

   assign irq_raw = |(pend_q & en);

   if (IRQ_REGISTERED) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_raw;
      end
      AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(|(pend_q & en)))); // R10
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(pend_q & ~clr_eff)) == $past(pend_q & ~clr_eff))); // R7
   AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt & clr_eff) != '0) |=> ((pend_q & $past(evt & clr_eff)) == $past(evt & clr_eff))); // R9
endmodule

// File: rtl/tachtmr_regif.sv
module tachtmr_regif
   import tachtmr_pkg::*;
#(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 16,
   parameter int NUM_EVT        = 6,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               req_size,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic               rsp_err,
   input  logic [DATA_W-1:0]  cnt1_val,
   input  logic [DATA_W-1:0]  cap_a_val,
   input  logic [DATA_W-1:0]  cap_b_val,
   input  logic [DATA_W-1:0]  cnt2_val,
   input  logic [NUM_EVT-1:0] evt_pulse,
   output logic [7:0]         prescale,
   output logic               clk1_gate,
   output logic               clk2_gate,
   output logic               ch_a_en,
   output logic               ch_b_en,
   output logic               ch_a_edge,
   output logic               ch_b_edge,
   output logic               mode5_en,
   output logic [DATA_W-1:0]  cmp_a,
   output logic [DATA_W-1:0]  cmp_b,
   output logic [3:0]         cmp_cfg_a,
   output logic [3:0]         cmp_cfg_b,
   output logic               in_sel_a,
   output logic               in_sel_b,
   output logic               irq
);
   localparam int NIB_W = BYTE_W / 2;
   localparam int PAD_B = DATA_W - BYTE_W;
   localparam int PAD_E = DATA_W - NUM_EVT;

   if (DATA_W != HALF_W) begin : g_bad_data
      $error("DATA_W must equal HALF_W");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must be at least 6");
   end
   if (NUM_EVT < 1 || NUM_EVT > BYTE_W) begin : g_bad_evt
      $error("NUM_EVT must be 1..BYTE_W");
   end

   reg_ix_e           ix;
   logic              dec_err;
   logic              wr_ok;
   cfg_t              cfg_q;
   logic [NUM_EVT-1:0] pend_q;
   logic [DATA_W-1:0] rd_mux;

   tachtmr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr      (req_addr),
      .size_half (req_size),
      .ix        (ix),
      .err       (dec_err)
   );

   assign wr_ok = req_valid & req_write & ~dec_err;

   tachtmr_cfg_regs u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_ok (wr_ok),
      .ix    (ix),
      .wdata (req_wdata),
      .cfg_q (cfg_q)
   );

   tachtmr_pending #(.NUM_EVT(NUM_EVT), .IRQ_REGISTERED(IRQ_REGISTERED)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_pulse),
      .clr_we   (wr_ok && ix == IX_CLR),
      .clr_mask (req_wdata[NUM_EVT-1:0]),
      .en       (cfg_q.int_en[NUM_EVT-1:0]),
      .pend_q   (pend_q),
      .irq      (irq)
   );

   always_comb begin
      rd_mux = '0;
      unique case (ix)
         IX_CNT1: rd_mux = cnt1_val;
         IX_CAPA: rd_mux = cap_a_val;
         IX_CAPB: rd_mux = cap_b_val;
         IX_CNT2: rd_mux = cnt2_val;
         IX_PRSC: rd_mux = {{PAD_B{1'b0}}, cfg_q.prescale};
         IX_CLKC: rd_mux = {{PAD_B{1'b0}}, cfg_q.clk_ctl};
         IX_MODE: rd_mux = {{PAD_B{1'b0}}, cfg_q.mode_ctl};
         IX_PEND: rd_mux = {{PAD_E{1'b0}}, pend_q};
         IX_IEN:  rd_mux = {{PAD_B{1'b0}}, cfg_q.int_en};
         IX_CMPA: rd_mux = cfg_q.cmp_a;
         IX_CMPB: rd_mux = cfg_q.cmp_b;
         IX_CCFG: rd_mux = {{PAD_B{1'b0}}, cfg_q.cmp_cfg};
         IX_SELA: rd_mux = {{PAD_B{1'b0}}, cfg_q.sel_a};
         IX_SELB: rd_mux = {{PAD_B{1'b0}}, cfg_q.sel_b};
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid & dec_err;
         rsp_rdata <= (req_valid && !req_write && !dec_err) ? rd_mux : '0;
      end
   end

   assign prescale  = cfg_q.prescale;
   assign clk1_gate = cfg_q.clk_ctl[CLK1_BIT];
   assign clk2_gate = cfg_q.clk_ctl[CLK2_BIT];
   assign ch_a_en   = cfg_q.mode_ctl[EN_A_BIT];
   assign ch_b_en   = cfg_q.mode_ctl[EN_B_BIT];
   assign ch_a_edge = cfg_q.mode_ctl[EDGE_A_BIT];
   assign ch_b_edge = cfg_q.mode_ctl[EDGE_B_BIT];
   assign mode5_en  = cfg_q.mode_ctl[MODE5_BIT];
   assign cmp_a     = cfg_q.cmp_a;
   assign cmp_b     = cfg_q.cmp_b;
   assign cmp_cfg_a = cfg_q.cmp_cfg[NIB_W-1:0];
   assign cmp_cfg_b = cfg_q.cmp_cfg[BYTE_W-1:NIB_W];
   assign in_sel_a  = cfg_q.sel_a[0];
   assign in_sel_b  = cfg_q.sel_b[0];

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R4
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R4
   AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && dec_err) |=> $stable(cfg_q)); // R2
   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0)); // R3
   AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && ix == IX_CLR) |=> (rsp_rdata == '0)); // R8
   always_ff @(posedge clk) begin
      AST_RESET_IRQ_LOW: assert (rst_n || !irq); // R11
   end
endmodule

// File: tb/tb_tachtmr_regif.sv
module tb_tachtmr_regif;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [15:0] rsp_rdata;
   logic [15:0] cnt1_val = 16'h1111, cap_a_val = 16'h2222;
   logic [15:0] cap_b_val = 16'h3333, cnt2_val = 16'h4444;
   logic [5:0]  evt_pulse = '0;
   logic [7:0]  prescale;
   logic        clk1_gate, clk2_gate, ch_a_en, ch_b_en, ch_a_edge, ch_b_edge, mode5_en;
   logic [15:0] cmp_a, cmp_b;
   logic [3:0]  cmp_cfg_a, cmp_cfg_b;
   logic        in_sel_a, in_sel_b, irq;

   int total = 0;
   int bad = 0;
   logic        g_v, g_e;
   logic [15:0] g_d;

   always #4 clk = ~clk;

   tachtmr_regif dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic w, input logic [7:0] a, input logic sz,
                      input logic [15:0] d, input logic [5:0] ev);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz;
      req_wdata = d; evt_pulse = ev;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; evt_pulse = '0;
      g_v = rsp_valid; g_d = rsp_rdata; g_e = rsp_err;
   endtask

   task automatic pulse(input logic [5:0] m);
      @(negedge clk); evt_pulse = m;
      @(negedge clk); evt_pulse = '0;
   endtask

   task automatic t_reset;
      chk("R11 irq after reset", irq, 0);
      chk("R11 prescale after reset", prescale, 0);
      chk("R11 cmp_a after reset", cmp_a, 0);
      acc(0, 8'h0E, 0, 0, 0);
      chk("R11 pending after reset", g_d, 0);
   endtask

   task automatic t_cfg;
      acc(1, 8'h08, 0, 16'hFF5A, 0);
      acc(0, 8'h08, 0, 0, 0);
      chk("R4 rsp_valid", g_v, 1);
      chk("R6 prescale readback zero-extended", g_d, 16'h005A);
      chk("R6 prescale port", prescale, 8'h5A);
      acc(1, 8'h14, 1, 16'hBEEF, 0);
      acc(0, 8'h14, 1, 0, 0);
      chk("R6 cmp_a readback", g_d, 16'hBEEF);
      acc(1, 8'h16, 1, 16'h1357, 0);
      chk("R6 cmp_b port", cmp_b, 16'h1357);
      acc(1, 8'h0C, 0, 16'h0020, 0);
      chk("R12 mode 0x20 fields", {ch_b_en, ch_a_en, ch_b_edge, ch_a_edge, mode5_en}, 5'b01000);
      acc(1, 8'h0C, 0, 16'h0054, 0);
      chk("R12 mode 0x54 fields", {ch_b_en, ch_a_en, ch_b_edge, ch_a_edge, mode5_en}, 5'b10101);
      acc(1, 8'h0A, 0, 16'h0008, 0);
      chk("R12 clock gates 0x08", {clk2_gate, clk1_gate}, 2'b10);
      acc(1, 8'h0A, 0, 16'h0001, 0);
      chk("R12 clock gates 0x01", {clk2_gate, clk1_gate}, 2'b01);
      acc(1, 8'h18, 0, 16'h00A5, 0);
      chk("R12 compare config nibbles", {cmp_cfg_b, cmp_cfg_a}, 8'hA5);
      acc(1, 8'h1C, 0, 16'h0001, 0);
      chk("R12 select bits", {in_sel_b, in_sel_a}, 2'b10);
      acc(0, 8'h1C, 0, 0, 0);
      chk("R1 select B at 0x1C", g_d, 16'h0001);
   endtask

   task automatic t_size;
      acc(1, 8'h16, 0, 16'h00FF, 0);
      chk("R2 byte write to 16-bit err", g_e, 1);
      chk("R2 cmp_b unchanged", cmp_b, 16'h1357);
      acc(1, 8'h08, 1, 16'h0011, 0);
      chk("R2 16-bit write to byte err", g_e, 1);
      chk("R2 prescale unchanged", prescale, 8'h5A);
      acc(0, 8'h08, 1, 0, 0);
      chk("R2 wrong-size read data", {g_e, g_d}, {1'b1, 16'h0000});
      acc(0, 8'h00, 0, 0, 0);
      chk("R2 byte read of counter err", g_e, 1);
   endtask

   task automatic t_unmapped;
      acc(0, 8'h1E, 0, 0, 0);
      chk("R3 offset 0x1E", {g_e, g_d}, {1'b1, 16'h0});
      acc(0, 8'h09, 0, 0, 0);
      chk("R3 odd address", {g_e, g_d}, {1'b1, 16'h0});
      acc(0, 8'h48, 0, 0, 0);
      chk("R3 above window", {g_e, g_d}, {1'b1, 16'h0});
      @(negedge clk);
      chk("R4 no response when idle", rsp_valid, 0);
   endtask

   task automatic t_live;
      acc(0, 8'h00, 1, 0, 0); chk("R5 counter 1 live", g_d, 16'h1111);
      acc(0, 8'h02, 1, 0, 0); chk("R5 capture A live", g_d, 16'h2222);
      acc(0, 8'h04, 1, 0, 0); chk("R5 capture B live", g_d, 16'h3333);
      cnt2_val = 16'hA0B1;
      acc(0, 8'h06, 1, 0, 0); chk("R5 counter 2 live", g_d, 16'hA0B1);
      acc(1, 8'h00, 1, 16'hDEAD, 0);
      chk("R5 counter write no error", g_e, 0);
      acc(0, 8'h00, 1, 0, 0); chk("R5 counter write ignored", g_d, 16'h1111);
   endtask

   task automatic t_pend_irq;
      acc(1, 8'h12, 0, 16'h0000, 0);
      pulse(6'b000100);
      acc(0, 8'h0E, 0, 0, 0);
      chk("R7 underflow A sets bit 2", g_d, 16'h0004);
      chk("R10 irq low while disabled", irq, 0);
      acc(1, 8'h12, 0, 16'h0004, 0);
      chk("R10 irq not yet high", irq, 0);
      @(negedge clk);
      chk("R10 irq high one cycle later", irq, 1);
      acc(1, 8'h0E, 0, 16'h0000, 0);
      acc(0, 8'h0E, 0, 0, 0);
      chk("R5 pending write ignored", g_d, 16'h0004);
      acc(1, 8'h10, 0, 16'h0004, 0);
      chk("R10 irq held one cycle after clear", irq, 1);
      @(negedge clk);
      chk("R10 irq low after clear", irq, 0);
      acc(0, 8'h0E, 0, 0, 0);
      chk("R8 pending cleared", g_d, 16'h0000);
      acc(0, 8'h10, 0, 0, 0);
      chk("R8 clear reads zero", {g_e, g_d}, {1'b0, 16'h0});
      acc(1, 8'h12, 0, 16'h0020, 0);
      pulse(6'b100000);
      chk("R10 irq not yet high on event", irq, 0);
      @(negedge clk);
      chk("R10 compare-hit B raises irq", irq, 1);
   endtask

   task automatic t_collide;
      pulse(6'b010011);
      acc(1, 8'h10, 0, 16'h0033, 6'b000001);
      acc(0, 8'h0E, 0, 0, 0);
      chk("R9 event wins over clear", g_d, 16'h0001);
      acc(1, 8'h10, 0, 16'h0001, 0);
      acc(0, 8'h0E, 0, 0, 0);
      chk("R8 partial clear", g_d, 16'h0000);
   endtask

   task automatic t_reset_mid;
      acc(1, 8'h12, 0, 16'h003F, 0);
      pulse(6'b001000);
      @(negedge clk);
      chk("R10 irq before reset", irq, 1);
      rst_n = 1'b0;
      #1;
      chk("R11 irq low in reset", irq, 0);
      chk("R11 config cleared", {prescale, cmp_a, cmp_cfg_b, cmp_cfg_a}, 40'h0);
      @(negedge clk); rst_n = 1'b1;
      acc(0, 8'h0E, 0, 0, 0);
      chk("R11 pending cleared", g_d, 16'h0);
      acc(0, 8'h12, 0, 0, 0);
      chk("R11 enable cleared", g_d, 16'h0);
      acc(0, 8'h02, 1, 0, 0);
      chk("R11 capture A not cleared", g_d, 16'h2222);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cfg();
      t_size();
      t_unmapped();
      t_live();
      t_pend_irq();
      t_collide();
      t_reset_mid();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule